// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one NAND access request into the ordered stream of address bytes that the flash expects after a command cycle. A request gives an optional column address, an optional page (row) address, the device page size in bytes and the device capacity in MiB. The block works out how many column and row bytes the geometry needs and presents them one at a time to the downstream operation engine over a valid/ready handshake.

Transfers always cover a whole page, so the column bytes are always zero. Each byte carries a `last` flag that tells the engine to wait for completion after that cycle. When the stream ends, `seqDone` pulses for one cycle. Requests are taken only while the block is idle. They are latched on acceptance, so the request pins may change freely afterwards.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `addrValid`, `addrLast`, `seqDone` and `seqBusy` are all low.
- R2: With a column present, one column byte of value 0x00 is sent when the page size is 512 bytes or less, and two zero bytes are sent when it is larger than 512 bytes. Column bytes always come before row bytes.
- R3: The first column byte has `addrLast` high exactly when no row address is requested. The second column byte of a large-page device never has `addrLast` high.
- R4: With a row present, row bytes go out least significant first: row bits 7:0, then 15:8, then 23:16.
- R5: For a page size larger than 512 bytes, three row bytes are sent when the capacity is at least 256 MiB, and two otherwise.
- R6: For a page size of 512 bytes or less, three row bytes are sent when the capacity is at least 64 MiB, and two otherwise.
- R7: Only the final row byte has `addrLast` high. Earlier row bytes have it low.
- R8: A request with neither a column nor a row emits no byte, and `seqDone` is high in the cycle after the request is taken.
- R9: A byte is consumed only in a cycle where `addrValid` and `addrReady` are both high. While `addrReady` is low, `addrValid`, `addrByte` and `addrLast` hold their values.
- R10: `seqDone` is high for exactly one cycle, in the cycle after the final byte is consumed.
- R11: `seqStart` is ignored while `seqBusy` is high, including during the `seqDone` cycle. The stream in progress is not changed by new request pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seqStart | input | 1 | Request strobe, taken when idle |
| colPresent | input | 1 | Request includes a column address |
| rowPresent | input | 1 | Request includes a row address |
| pageBytes | input | PGSZ_W | Device page size in bytes |
| capMiB | input | CAP_W | Device capacity in MiB |
| rowAddr | input | ROW_W | Page (row) address |
| addrValid | output | 1 | Address byte available |
| addrReady | input | 1 | Engine accepts the byte |
| addrByte | output | 8 | Address byte value |
| addrLast | output | 1 | Wait for completion after this cycle |
| seqBusy | output | 1 | A request is in progress |
| seqDone | output | 1 | One-cycle end-of-stream pulse |

## Verification
The embedded properties check the following on every cycle: the byte and its flags stay stable under backpressure, `seqDone` follows one cycle after the final byte is consumed and never lasts two cycles, column slots always carry zero, and no byte is offered while idle. Some behaviour can only be shown by the directed scenarios: the byte count chosen for each page-size and capacity threshold, the least-significant-first row order, the odd `last` placement on column-only large-page requests, the empty request, and a start pulse dropped mid-stream. These scenarios compare the full stream against a model built from the requirements.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SEND   = 2'd1,
    SQ_FINISH = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request and clear slot index
    logic advance;  // current byte consumed
  } seqStrobe_t;

  // Number of row bytes for a given geometry
  function automatic logic [1:0] rowByteCount(input logic rowReq, input logic threeRow);
    if (!rowReq)       return 2'd0;
    else if (threeRow) return 2'd3;
    else               return 2'd2;
  endfunction

  // Number of column bytes for a given geometry
  function automatic logic [1:0] colByteCount(input logic colReq, input logic bigPage);
    if (!colReq)      return 2'd0;
    else if (bigPage) return 2'd2;
    else              return 2'd1;
  endfunction

endpackage

// File: rtl/addr_seq_dp.sv
module addr_seq_dp
  import addr_seq_pkg::*;
#(
  parameter int PGSZ_W        = 16,
  parameter int CAP_W         = 16,
  parameter int ROW_W         = 24,
  parameter int SMALL_PAGE    = 512,
  parameter int BIG_CAP_MIB   = 256,
  parameter int SMALL_CAP_MIB = 64,
  parameter int IDX_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic              colPresent,
  input  logic              rowPresent,
  input  logic [PGSZ_W-1:0] pageBytes,
  input  logic [CAP_W-1:0]  capMiB,
  input  logic [ROW_W-1:0]  rowAddr,
  output logic              reqEmpty,
  output logic              atFinal,
  output logic [7:0]        byteOut,
  output logic              lastOut
);

  localparam int LANES   = (ROW_W + 7) / 8;
  localparam int PADDED  = LANES * 8;

  // Geometry decode from the live request pins
  logic liveBig, liveThree;
  logic [1:0] liveCol, liveRow;
  always_comb begin
    liveBig   = (pageBytes > PGSZ_W'(SMALL_PAGE));
    liveThree = liveBig ? (capMiB >= CAP_W'(BIG_CAP_MIB))
                        : (capMiB >= CAP_W'(SMALL_CAP_MIB));
    liveCol   = colByteCount(colPresent, liveBig);
    liveRow   = rowByteCount(rowPresent, liveThree);
    reqEmpty  = (liveCol == 2'd0) && (liveRow == 2'd0);
  end

  // Latched request
  logic [1:0]        colCnt, rowCnt;
  logic              rowReq;
  logic [PADDED-1:0] rowReg;
  logic [IDX_W-1:0]  slotIdx;
  logic [IDX_W-1:0]  slotTotal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colCnt    <= '0;
      rowCnt    <= '0;
      rowReq    <= 1'b0;
      rowReg    <= '0;
      slotIdx   <= '0;
      slotTotal <= '0;
    end else if (strobe.load) begin
      colCnt    <= liveCol;
      rowCnt    <= liveRow;
      rowReq    <= rowPresent;
      rowReg    <= PADDED'(rowAddr);
      slotIdx   <= '0;
      slotTotal <= IDX_W'(liveCol) + IDX_W'(liveRow);
    end else if (strobe.advance) begin
      slotIdx   <= slotIdx + 1'b1;
    end
  end

  // Row byte lanes
  logic [7:0] rowLane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rowLane[g] = rowReg[g*8 +: 8];
  end

  logic             inCol;
  logic [IDX_W-1:0] rowSlot;
  always_comb begin
    inCol   = (slotIdx < IDX_W'(colCnt));
    rowSlot = slotIdx - IDX_W'(colCnt);
    atFinal = (slotIdx + 1'b1 == slotTotal);
    byteOut = 8'h00;
    lastOut = 1'b0;
    if (inCol) begin
      byteOut = 8'h00;
      lastOut = (slotIdx == '0) && !rowReq;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (rowSlot == IDX_W'(k)) byteOut = rowLane[k];
      end
      lastOut = (rowSlot + 1'b1 == IDX_W'(rowCnt));
    end
  end

  // Column slots never carry a non-zero byte (R2)
  p_col_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slotIdx < IDX_W'(colCnt)) |-> (byteOut == 8'h00));

  // A second column byte never carries the last flag (R3)
  p_second_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slotIdx == IDX_W'(1) && colCnt == 2'd2) |-> !lastOut);

endmodule

// File: rtl/addr_seq_ctrl.sv
module addr_seq_ctrl
  import addr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seqStart,
  input  logic       reqEmpty,
  input  logic       atFinal,
  input  logic       addrReady,
  output seqStrobe_t strobe,
  output logic       addrValid,
  output logic       seqBusy,
  output logic       seqDone
);

  seqState_t state, stateNext;
  logic fire;

  always_comb begin
    addrValid      = (state == SQ_SEND);
    fire           = addrValid && addrReady;
    strobe.load    = (state == SQ_IDLE) && seqStart;
    strobe.advance = fire;
    stateNext      = state;
    case (state)
      SQ_IDLE:   if (seqStart) stateNext = reqEmpty ? SQ_FINISH : SQ_SEND;
      SQ_SEND:   if (fire && atFinal) stateNext = SQ_FINISH;
      SQ_FINISH: stateNext = SQ_IDLE;
      default:   stateNext = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= stateNext;
  end

  assign seqBusy = (state != SQ_IDLE);
  assign seqDone = (state == SQ_FINISH);

  // Done follows acceptance of the final byte (R10)
  p_done_after_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && addrReady && atFinal) |=> seqDone);

  // Done is a single-cycle pulse (R10)
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |=> !seqDone);

  // Valid is held under backpressure (R9)
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && !addrReady) |=> addrValid);

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import addr_seq_pkg::*;
#(
  parameter int PGSZ_W        = 16,
  parameter int CAP_W         = 16,
  parameter int ROW_W         = 24,
  parameter int SMALL_PAGE    = 512,
  parameter int BIG_CAP_MIB   = 256,
  parameter int SMALL_CAP_MIB = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seqStart,
  input  logic              colPresent,
  input  logic              rowPresent,
  input  logic [PGSZ_W-1:0] pageBytes,
  input  logic [CAP_W-1:0]  capMiB,
  input  logic [ROW_W-1:0]  rowAddr,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [7:0]        addrByte,
  output logic              addrLast,
  output logic              seqBusy,
  output logic              seqDone
);

  localparam int MAX_SLOTS = 2 + 3;
  localparam int IDX_W     = $clog2(MAX_SLOTS + 1);

  seqStrobe_t strobe;
  logic reqEmpty, atFinal;
  logic [7:0] dpByte;
  logic dpLast;

  addr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .seqStart  (seqStart),
    .reqEmpty  (reqEmpty),
    .atFinal   (atFinal),
    .addrReady (addrReady),
    .strobe    (strobe),
    .addrValid (addrValid),
    .seqBusy   (seqBusy),
    .seqDone   (seqDone)
  );

  addr_seq_dp #(
    .PGSZ_W        (PGSZ_W),
    .CAP_W         (CAP_W),
    .ROW_W         (ROW_W),
    .SMALL_PAGE    (SMALL_PAGE),
    .BIG_CAP_MIB   (BIG_CAP_MIB),
    .SMALL_CAP_MIB (SMALL_CAP_MIB),
    .IDX_W         (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .colPresent (colPresent),
    .rowPresent (rowPresent),
    .pageBytes  (pageBytes),
    .capMiB     (capMiB),
    .rowAddr    (rowAddr),
    .reqEmpty   (reqEmpty),
    .atFinal    (atFinal),
    .byteOut    (dpByte),
    .lastOut    (dpLast)
  );

  assign addrByte = addrValid ? dpByte : 8'h00;
  assign addrLast = addrValid & dpLast;

  // Byte and flag stable while stalled (R9)
  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && !addrReady) |=> ($stable(addrByte) && $stable(addrLast)));

  // Nothing offered while idle (R1)
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seqBusy |-> (!addrValid && !seqDone));

endmodule

// File: tb/nand_addr_seq_bench.sv
module nand_addr_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seqStart = 1'b0, colPresent = 1'b0, rowPresent = 1'b0, addrReady = 1'b0;
  logic [15:0] pageBytes = 16'd512;
  logic [15:0] capMiB = 16'd32;
  logic [23:0] rowAddr = 24'h0;
  logic addrValid, addrLast, seqBusy, seqDone;
  logic [7:0] addrByte;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  nand_addr_seq u_nand_addr_seq (
    .clk(clk), .rst_n(rst_n), .seqStart(seqStart), .colPresent(colPresent),
    .rowPresent(rowPresent), .pageBytes(pageBytes), .capMiB(capMiB),
    .rowAddr(rowAddr), .addrValid(addrValid), .addrReady(addrReady),
    .addrByte(addrByte), .addrLast(addrLast), .seqBusy(seqBusy), .seqDone(seqDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [7:0] expByte [5];
  bit         expLast [5];
  int         expN;

  function automatic void buildExpect(input bit c, input bit r, input int pg,
                                      input int cap, input logic [23:0] row);
    bit big = (pg > 512);
    bit three = big ? (cap >= 256) : (cap >= 64);
    expN = 0;
    if (c) begin
      expByte[expN] = 8'h00; expLast[expN] = !r; expN++;
      if (big) begin expByte[expN] = 8'h00; expLast[expN] = 1'b0; expN++; end
    end
    if (r) begin
      int rb = three ? 3 : 2;
      for (int k = 0; k < rb; k++) begin
        expByte[expN] = row[k*8 +: 8]; expLast[expN] = (k == rb - 1); expN++;
      end
    end
  endfunction

  task automatic runCase(input string tag, input bit c, input bit r, input int pg,
                         input int cap, input logic [23:0] row, input bit stall,
                         input bit poke);
    int got = 0, doneAt = -1, doneCount = 0, finalCyc = 0;
    bit prevHold = 0;
    logic [7:0] prevByte = 8'h00;
    bit prevLast = 0;
    buildExpect(c, r, pg, cap, row);
    @(negedge clk);
    colPresent = c; rowPresent = r; pageBytes = 16'(pg); capMiB = 16'(cap);
    rowAddr = row; seqStart = 1'b1; addrReady = 1'b0;
    @(negedge clk);
    seqStart = 1'b0;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      if (prevHold)
        check(addrValid && addrByte == prevByte && addrLast == prevLast,
              {tag, " R9 hold"}, int'(addrByte), int'(prevByte));
      if (seqDone) begin
        doneCount++;
        if (doneAt < 0) doneAt = cyc;
      end
      addrReady = stall ? ((cyc % 3) != 1) : 1'b1;
      if (poke && cyc == 2) begin
        seqStart = 1'b1; colPresent = 1'b0; rowPresent = 1'b0; rowAddr = 24'hFFFFFF;
      end else begin
        seqStart = 1'b0;
      end
      if (addrValid && addrReady) begin
        if (got < expN) begin
          check(addrByte == expByte[got], {tag, " byte value"},
                int'(addrByte), int'(expByte[got]));
          check(addrLast == expLast[got], {tag, " last flag"},
                int'(addrLast), int'(expLast[got]));
        end
        got++;
        if (got == expN) finalCyc = cyc;
      end
      prevHold = addrValid && !addrReady;
      prevByte = addrByte;
      prevLast = addrLast;
      @(negedge clk);
    end
    addrReady = 1'b0;
    check(got == expN, {tag, " byte count"}, got, expN);
    check(doneAt == finalCyc + 1, {tag, " R10 done timing"}, doneAt, finalCyc + 1);
    check(doneCount == 1, {tag, " R10 done single pulse"}, doneCount, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!addrValid && !addrLast && !seqDone && !seqBusy, "R1 reset outputs",
          {addrValid, addrLast, seqDone, seqBusy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!addrValid && !seqBusy, "R1 idle after reset", {addrValid, seqBusy}, 0);

    runCase("R2 R4 R6 small 32MiB",   1, 1, 512,  32,  24'h123456, 0, 0);
    runCase("R6 R7 small 64MiB",      1, 1, 512,  64,  24'h123456, 0, 0);
    runCase("R5 R9 large 255MiB stall", 1, 1, 2048, 255, 24'hA1B2C3, 1, 0);
    runCase("R5 R7 large 256MiB",     1, 1, 2048, 256, 24'hA1B2C3, 0, 0);
    runCase("R3 column only large",   1, 0, 2048, 512, 24'h0, 0, 0);
    runCase("R3 column only small",   1, 0, 512,  16,  24'h0, 0, 0);
    runCase("R4 row only small",      0, 1, 512,  16,  24'h00BEEF, 1, 0);
    runCase("R8 empty request",       0, 0, 2048, 512, 24'h0, 0, 0);
    runCase("R11 start while busy",   1, 1, 4096, 1024, 24'h5A6B7C, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule